// File: doc/BRIEF.md
# Programmable Phase-Shifted Clock Divider

This block produces the forwarded transmit clock for one serial-link channel. A counter divides the system clock by a programmed factor. Two further programmed counter positions mark where the divided clock goes high and where it goes low. Together they set the duty cycle and the phase of the output. The output is a registered signal. A one-cycle marker pulse flags the first cycle of every divided period. One instance serves one channel.

The divide factor and the two edge positions are taken into shadow registers only at a period boundary, or while the divider is idle. A change made in the middle of a period therefore never produces a shortened or stretched period. A clock-enable and a software synchronous reset both stop the divider, force the output low and restart the count from zero.

Top module: `phase_clk_div`

## Requirements
- R1: After `rst_ni` is released, the active settings are divide 8 with rise position 2 and fall position 6 when `DDR_EN`=1, or rise position 4 and fall position 0 when `DDR_EN`=0. These settings govern the first period if the divider is already enabled. With `DDR_EN`=1 that first period holds `clk_o` high for exactly 4 of its 8 cycles.
- R2: While running, an internal count steps 0,1,...,D-1 and then returns to 0, where D is the effective divide factor. `clk_o` therefore repeats every D cycles.
- R3: `clk_o` becomes 1 in the cycle after the count equals the rise position. It becomes 0 in the cycle after the count equals the fall position. If the two positions are equal, `clk_o` keeps its value. A position of D or above never acts.
- R4: `period_o` is high for exactly one cycle: the cycle in which the count is 0 following a wrap. It is high once every D cycles.
- R5: New values on `div_i`, `rise_i` and `fall_i` are captured only in the wrap cycle, or while the divider is idle. A change made mid-period does not affect the current period.
- R6: A divide value of 0 or 1 acts as a divide of 2.
- R7: While `clk_en_i`=0, `clk_o` and `period_o` are 0 from the next cycle on. The count is held at 0, and the inputs are captured as the active settings.
- R8: While `soft_rst_ni`=0, the block behaves as in R7, whatever the value of `clk_en_i`.
- R9: `rst_ni`=0 asynchronously clears `clk_o`, `period_o` and the count, and restores the R1 settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_ni | input | 1 | Synchronous software reset, active low |
| clk_en_i | input | 1 | Divider enable, active high |
| div_i | input | LOG2_MAX_DIV+1 | Divide factor |
| rise_i | input | LOG2_MAX_DIV+1 | Count at which the output rises |
| fall_i | input | LOG2_MAX_DIV+1 | Count at which the output falls |
| clk_o | output | 1 | Divided, phase-shifted clock (registered) |
| period_o | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
A period wrap, which captures new settings, can fall in the same cycle as an edge. Two settings provoke this. A rise position of 0 acts on the first cycle of the new settings. A fall position of D-1 acts on the wrap cycle itself, while the old settings are still active. The bench drives these settings and also changes the inputs mid-period. A scoreboard model predicts `clk_o` and `period_o` for every cycle, and any disagreement in those shared cycles counts as a miscompare.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned DIV_RST      = 8;
  localparam int unsigned RISE_RST_DDR = 2;
  localparam int unsigned FALL_RST_DDR = 6;
  localparam int unsigned RISE_RST_SDR = 4;
  localparam int unsigned FALL_RST_SDR = 0;
  localparam int unsigned MIN_DIV      = 2;

  function automatic int unsigned rise_rst(bit ddr);
    return ddr ? RISE_RST_DDR : RISE_RST_SDR;
  endfunction

  function automatic int unsigned fall_rst(bit ddr);
    return ddr ? FALL_RST_DDR : FALL_RST_SDR;
  endfunction
endpackage

// File: rtl/pcd_cfg_shadow.sv
module pcd_cfg_shadow #(
  parameter int unsigned W        = 11,
  parameter int unsigned DEF_DIV  = 8,
  parameter int unsigned DEF_RISE = 2,
  parameter int unsigned DEF_FALL = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] div_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] eff_div_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] div_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= W'(DEF_DIV);
      rise_q <= W'(DEF_RISE);
      fall_q <= W'(DEF_FALL);
    end else if (load_i) begin
      div_q  <= div_i;
      rise_q <= rise_i;
      fall_q <= fall_i;
    end
  end

  // divide of 0 or 1 would never wrap cleanly
  assign eff_div_o = (div_q < W'(pcd_pkg::MIN_DIV)) ? W'(pcd_pkg::MIN_DIV) : div_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(div_q) && $stable(rise_q) && $stable(fall_q))); // R5
endmodule

// File: rtl/pcd_counter.sv
module pcd_counter #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] eff_div_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == eff_div_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < eff_div_i)); // R2
  AST_CNT_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/pcd_edge_gen.sv
module pcd_edge_gen #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic         clk_o,
  output logic         period_o
);
  logic clk_q, period_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= 1'b0;
      period_q <= 1'b0;
    end else if (!run_i) begin
      clk_q    <= 1'b0;
      period_q <= 1'b0;
    end else begin
      period_q <= wrap_i;
      if (rise_i != fall_i) begin
        if (cnt_i == rise_i)      clk_q <= 1'b1;
        else if (cnt_i == fall_i) clk_q <= 1'b0;
      end
    end
  end

  assign clk_o    = clk_q;
  assign period_o = period_q;

  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == rise_i && rise_i != fall_i) |=> clk_q); // R3
  AST_FALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == fall_i && rise_i != fall_i) |=> !clk_q); // R3
  AST_EQUAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rise_i == fall_i) |=> $stable(clk_q)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!clk_q && !period_q)); // R7
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
  parameter int unsigned LOG2_MAX_DIV = 10,
  parameter bit          DDR_EN       = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_ni,
  input  logic                  clk_en_i,
  input  logic [LOG2_MAX_DIV:0] div_i,
  input  logic [LOG2_MAX_DIV:0] rise_i,
  input  logic [LOG2_MAX_DIV:0] fall_i,
  output logic                  clk_o,
  output logic                  period_o
);
  localparam int unsigned W        = LOG2_MAX_DIV + 1;
  localparam int unsigned DEF_RISE = pcd_pkg::rise_rst(DDR_EN);
  localparam int unsigned DEF_FALL = pcd_pkg::fall_rst(DDR_EN);

  logic         run, wrap;
  logic [W-1:0] eff_div, act_rise, act_fall, cnt;

  assign run = soft_rst_ni && clk_en_i;

  pcd_cfg_shadow #(
    .W(W), .DEF_DIV(pcd_pkg::DIV_RST), .DEF_RISE(DEF_RISE), .DEF_FALL(DEF_FALL)
  ) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (!run || wrap),
    .div_i     (div_i),
    .rise_i    (rise_i),
    .fall_i    (fall_i),
    .eff_div_o (eff_div),
    .rise_o    (act_rise),
    .fall_o    (act_fall)
  );

  pcd_counter #(.W(W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .eff_div_i (eff_div),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  pcd_edge_gen #(.W(W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .wrap_i   (wrap),
    .cnt_i    (cnt),
    .rise_i   (act_rise),
    .fall_i   (act_fall),
    .clk_o    (clk_o),
    .period_o (period_o)
  );

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o); // R4
  AST_PULSE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |-> (cnt == '0)); // R4
  AST_SOFT_RST_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_ni |=> (!clk_o && !period_o)); // R8
  AST_DIV_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && div_i < 2 && wrap) |=> ##1 (cnt == 1 || !run)); // R6
endmodule

// File: tb/phase_clk_div_bench.sv
module phase_clk_div_bench;
  localparam int unsigned LOG2_MAX_DIV = 10;
  localparam int unsigned W = LOG2_MAX_DIV + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         soft_n = 1'b1;
  logic         en = 1'b1;
  logic [W-1:0] div = W'(5), rise = W'(1), fall = W'(3);
  logic         clk_o, period_o;

  int vectors = 0;
  int miscompares = 0;
  string req = "R1";
  logic [1:0] exp_q [$];

  always #5 clk = ~clk;

  phase_clk_div #(.LOG2_MAX_DIV(LOG2_MAX_DIV), .DDR_EN(1'b1)) u_phase_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_ni(soft_n), .clk_en_i(en),
    .div_i(div), .rise_i(rise), .fall_i(fall), .clk_o(clk_o), .period_o(period_o)
  );

  // reference model written from the requirements; pushes expected outputs
  int m_cnt = 0, m_div = 8, m_rise = 2, m_fall = 6;
  logic m_clk = 1'b0, m_per = 1'b0;
  always @(posedge clk) begin
    int d;
    logic wr;
    if (!rst_n) begin
      m_cnt = 0; m_div = 8; m_rise = 2; m_fall = 6; m_clk = 1'b0; m_per = 1'b0;
    end else if (!soft_n || !en) begin
      m_cnt = 0; m_clk = 1'b0; m_per = 1'b0;
      m_div = int'(div); m_rise = int'(rise); m_fall = int'(fall);
    end else begin
      d = (m_div < 2) ? 2 : m_div;
      wr = (m_cnt == d - 1);
      m_per = wr;
      if (m_rise != m_fall) begin
        if (m_cnt == m_rise) m_clk = 1'b1;
        else if (m_cnt == m_fall) m_clk = 1'b0;
      end
      m_cnt = wr ? 0 : m_cnt + 1;
      if (wr) begin
        m_div = int'(div); m_rise = int'(rise); m_fall = int'(fall);
      end
    end
    exp_q.push_back({m_clk, m_per});
  end

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    logic [1:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      vectors++;
      if ({clk_o, period_o} !== e) begin
        miscompares++;
        $display("FAIL %s t=%0t clk_o=%b exp %b period_o=%b exp %b",
                 req, $time, clk_o, e[1], period_o, e[0]);
      end
    end
  end

  task automatic check(string r, int got, int expv);
    vectors++;
    if (got != expv) begin
      miscompares++;
      $display("FAIL %s directed: got %0d exp %0d", r, got, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(int d, int r, int f);
    div = W'(d); rise = W'(r); fall = W'(f);
  endtask

  task automatic count_win(int n, output int highs, output int pulses);
    highs = 0; pulses = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      highs += int'(clk_o);
      pulses += int'(period_o);
    end
  endtask

  initial begin
    int h, p;
    // R9 R1: reset while enabled with different inputs pending
    step(3);
    #1;
    check("R9", int'({clk_o, period_o}), 0);
    @(negedge clk); rst_n = 1'b1;
    req = "R1";
    count_win(8, h, p);
    check("R1", h, 4);
    req = "R2"; step(20);
    // R3: rise at 0 and fall at D-1 share cycles with the wrap
    req = "R3"; set_cfg(7, 0, 6); step(30);
    set_cfg(6, 2, 2); step(20);
    set_cfg(6, 9, 3); step(20);
    // R5: change mid-period
    req = "R5"; set_cfg(10, 2, 7); step(14); set_cfg(4, 1, 2); step(3);
    set_cfg(9, 3, 8); step(30);
    // R6: divide 0 and 1
    req = "R6"; set_cfg(0, 0, 1); step(12);
    count_win(20, h, p);
    check("R6", p, 10);
    set_cfg(1, 1, 0); step(12);
    count_win(20, h, p);
    check("R6", p, 10);
    check("R6", h, 10);
    // R7: enable low
    req = "R7"; set_cfg(8, 3, 5); step(10);
    en = 1'b0;
    count_win(5, h, p);
    check("R7", h + p, 0);
    en = 1'b1; step(20);
    // R8: soft reset overrides enable
    req = "R8"; soft_n = 1'b0;
    count_win(4, h, p);
    check("R8", h + p, 0);
    soft_n = 1'b1; step(20);
    // R4: pulse rate
    req = "R4"; set_cfg(3, 0, 1); step(10);
    count_win(30, h, p);
    check("R4", p, 10);
    check("R4", h, 10);
    // R9: asynchronous reset mid-run
    req = "R9"; rst_n = 1'b0; #2;
    check("R9", int'({clk_o, period_o}), 0);
    step(2); rst_n = 1'b1;
    count_win(8, h, p);
    check("R1", h, 4);
    req = "R2"; set_cfg(100, 10, 60); step(250);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired in %s", req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule